// File: doc/BRIEF.md
# 2D DMA Source-Address Sequencer

This block produces the stream of source read addresses for one display DMA channel. Software fills a programmed parameter set: a start address, an element count, a frame count, a signed element stride, a signed frame stride and an element width. It then commits that set into an active set that the address walker uses. Once enabled, the walker offers one address per cycle to a downstream reader. It advances only when that reader accepts the address.

In linear mode the address steps by the element width. In double-index mode it uses separate signed strides inside a frame and across frame boundaries, which covers rotated, mirrored and scaled frame-buffer scans. A block is element count times frame count accesses. At the end of a block the walker either stops or restarts from the start address, and it sets a sticky completion status that can raise an interrupt.

A commit written while a block is running is held back until that block ends. The channel can therefore be reprogrammed without tearing a frame.

Top module: `sdma2d_seq`

## Requirements
- R1: The element width in bytes comes from the 2-bit type register (offset 7, bits 1:0): code 0 gives 1, code 1 gives 2, codes 2 and 3 give 4.
- R2: When the mode field (channel register bits 13:12) is not 3, every accepted address is followed by the previous address plus the element width, including across frame ends.
- R3: When the mode field equals 3, an accepted address that is not the last of its frame is followed by that address plus width plus element stride minus 1. The element stride is 16-bit signed, at offset 5.
- R4: When the mode field equals 3, the last address of a non-final frame is followed by that address plus width plus frame stride minus 1. The frame stride is 32-bit signed, at offset 6. A block ends after element count (offset 3) times frame count (offset 4) accepted addresses.
- R5: Writing the channel register (offset 0) with bit 7 set while idle makes `busy` and `src_valid` high from the next cycle, presenting the active start address. Writing bit 7 clear makes both low from the next cycle.
- R6: Writing channel bit 11 while idle copies the programmed set (start address at offset 2, offsets 3 to 7) into the active set at once. When bit 7 is set in the same write, the walk starts from the new start address. Programmed writes without that bit leave the active set unchanged.
- R7: Writing channel bit 11 while running leaves the current block on its old parameters. The copy is made at the block end, and the following block uses the new set.
- R8: With channel bits 9:8 both set, the address after the last one of a block is the active start address and `busy` stays high. Otherwise the enable bit clears and `busy` drops in the cycle after the last acceptance.
- R9: Block end sets status bit 3 of the interrupt register (offset 1). Writing 1 to bit 3 clears it, and writing 0 leaves it set. `irq` is high exactly when the status and the interrupt enable (bit 1 of the same register) are both set.
- R10: While `src_valid` is high and `src_ready` is low, the address and counters hold unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write offset |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_addr | input | 3 | Register read offset |
| reg_rd_data | output | 32 | Register read data (combinational) |
| src_valid | output | 1 | A source address is offered |
| src_addr | output | 32 | Source read address |
| src_ready | input | 1 | Downstream accepts the offered address |
| busy | output | 1 | Channel enabled and walking |
| irq | output | 1 | Block-complete interrupt |

## Verification
The hardest case is a commit that arrives mid-block while the channel repeats. The remaining accesses must still follow the old strides, and the restart after the block end must pick up the new start address and strides. The stimulus reaches this by running a repeating double-index block part way with random stalls, parking the ready line low, and rewriting every parameter. It then issues the commit and streams through the rest of the old block and the whole new one against a bench model that keeps its own pending copy. Random configurations with negative strides and every width code, plus a commit folded into the start write, cover the remaining orderings.

// File: rtl/sdma2d_pkg.sv
package sdma2d_pkg;

    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int EIDX_W = 16;
    localparam int FIDX_W = 32;
    localparam int DATA_W = 32;
    localparam int RA_W   = 3;

    // register offsets
    localparam logic [RA_W-1:0] RA_CHAN  = 3'd0;
    localparam logic [RA_W-1:0] RA_IRQ   = 3'd1;
    localparam logic [RA_W-1:0] RA_TOP   = 3'd2;
    localparam logic [RA_W-1:0] RA_ECNT  = 3'd3;
    localparam logic [RA_W-1:0] RA_FCNT  = 3'd4;
    localparam logic [RA_W-1:0] RA_EIDX  = 3'd5;
    localparam logic [RA_W-1:0] RA_FIDX  = 3'd6;
    localparam logic [RA_W-1:0] RA_DTYPE = 3'd7;

    // channel register bit positions
    localparam int CB_EN      = 7;
    localparam int CB_REP_LO  = 8;
    localparam int CB_EOP     = 11;
    localparam int CB_MODE_LO = 12;
    // interrupt register bit positions
    localparam int IB_IEN  = 1;
    localparam int IB_STAT = 3;

    localparam logic [1:0] MODE_DBL = 2'b11;
    localparam logic [1:0] REP_ON   = 2'b11;

    typedef enum logic [1:0] {
        DT_B8  = 2'd0,
        DT_B16 = 2'd1,
        DT_B32 = 2'd2,
        DT_RSV = 2'd3
    } dtype_e;

    typedef struct packed {
        logic [ADDR_W-1:0]        top;
        logic [CNT_W-1:0]         ecnt;
        logic [CNT_W-1:0]         fcnt;
        logic signed [EIDX_W-1:0] eidx;
        logic signed [FIDX_W-1:0] fidx;
        dtype_e                   dt;
    } xfer_set_t;

    function automatic logic [ADDR_W-1:0] elem_bytes(input dtype_e dt);
        case (dt)
            DT_B8:   return ADDR_W'(1);
            DT_B16:  return ADDR_W'(2);
            default: return ADDR_W'(4);
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] stride(input dtype_e dt, input logic dbl,
                                                 input logic [ADDR_W-1:0] idx);
        if (dbl)
            return elem_bytes(dt) + idx - ADDR_W'(1);
        return elem_bytes(dt);
    endfunction

endpackage

// File: rtl/sdma2d_regs.sv
module sdma2d_regs
    import sdma2d_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [RA_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              blk_done,
    output logic              run,
    output logic              dbl_mode,
    output logic              rep_on,
    output logic              start_p,
    output logic              ep_p,
    output logic              irq_en,
    output logic              stat,
    output logic              irq,
    output xfer_set_t         prog
);

    logic       en_q;
    logic [1:0] rep_q;
    logic [1:0] mode_q;
    logic       ien_q;
    logic       stat_q;
    xfer_set_t  prog_q;
    logic       chan_wr;
    logic       irq_wr;

    assign chan_wr  = wr_en && (wr_addr == RA_CHAN);
    assign irq_wr   = wr_en && (wr_addr == RA_IRQ);
    assign start_p  = chan_wr && wr_data[CB_EN] && !en_q;
    assign ep_p     = chan_wr && wr_data[CB_EOP];
    assign run      = en_q;
    assign dbl_mode = (mode_q == MODE_DBL);
    assign rep_on   = (rep_q == REP_ON);
    assign irq_en   = ien_q;
    assign stat     = stat_q;
    assign irq      = stat_q && ien_q;
    assign prog     = prog_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            rep_q  <= 2'b00;
            mode_q <= 2'b00;
            ien_q  <= 1'b0;
            stat_q <= 1'b0;
            prog_q <= '0;
        end else begin
            // a finished single block drops the enable; a write in the same cycle wins
            if (blk_done && !rep_on)
                en_q <= 1'b0;
            if (chan_wr) begin
                en_q   <= wr_data[CB_EN];
                rep_q  <= wr_data[CB_REP_LO +: 2];
                mode_q <= wr_data[CB_MODE_LO +: 2];
            end
            if (irq_wr)
                ien_q <= wr_data[IB_IEN];
            // status: set beats clear
            if (blk_done)
                stat_q <= 1'b1;
            else if (irq_wr && wr_data[IB_STAT])
                stat_q <= 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    RA_TOP:   prog_q.top  <= wr_data[ADDR_W-1:0];
                    RA_ECNT:  prog_q.ecnt <= wr_data[CNT_W-1:0];
                    RA_FCNT:  prog_q.fcnt <= wr_data[CNT_W-1:0];
                    RA_EIDX:  prog_q.eidx <= wr_data[EIDX_W-1:0];
                    RA_FIDX:  prog_q.fidx <= wr_data[FIDX_W-1:0];
                    RA_DTYPE: prog_q.dt   <= dtype_e'(wr_data[1:0]);
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_CHAN: begin
                rd_data[CB_EN]              = en_q;
                rd_data[CB_REP_LO +: 2]     = rep_q;
                rd_data[CB_MODE_LO +: 2]    = mode_q;
            end
            RA_IRQ: begin
                rd_data[IB_IEN]  = ien_q;
                rd_data[IB_STAT] = stat_q;
            end
            RA_TOP:   rd_data = DATA_W'(prog_q.top);
            RA_ECNT:  rd_data = DATA_W'(prog_q.ecnt);
            RA_FCNT:  rd_data = DATA_W'(prog_q.fcnt);
            RA_EIDX:  rd_data = DATA_W'($unsigned(prog_q.eidx));
            RA_FIDX:  rd_data = DATA_W'($unsigned(prog_q.fidx));
            RA_DTYPE: rd_data = DATA_W'(prog_q.dt);
            default: ;
        endcase
    end

endmodule

// File: rtl/sdma2d_addr_gen.sv
module sdma2d_addr_gen
    import sdma2d_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              start_p,
    input  logic              ep_p,
    input  logic              dbl_mode,
    input  xfer_set_t         prog,
    input  logic              src_ready,
    output logic [ADDR_W-1:0] src_addr,
    output logic              blk_done
);

    xfer_set_t                act_q;
    logic                     pend_q;
    logic [ADDR_W-1:0]        addr_q;
    logic [CNT_W-1:0]         ecnt_q;
    logic [CNT_W-1:0]         fcnt_q;
    logic                     load_now;
    logic                     acc;
    logic                     last_e;
    logic                     last_f;
    logic signed [ADDR_W-1:0] e_ext;
    logic signed [ADDR_W-1:0] f_ext;
    logic [ADDR_W-1:0]        step_e;
    logic [ADDR_W-1:0]        step_f;
    logic [ADDR_W-1:0]        restart;

    assign load_now = ep_p && !run;
    assign acc      = run && src_ready;
    assign last_e   = (ecnt_q == act_q.ecnt - CNT_W'(1));
    assign last_f   = (fcnt_q == act_q.fcnt - CNT_W'(1));
    assign blk_done = acc && last_e && last_f;
    assign e_ext    = ADDR_W'(act_q.eidx);
    assign f_ext    = ADDR_W'(act_q.fidx);
    assign step_e   = stride(act_q.dt, dbl_mode, e_ext);
    assign step_f   = stride(act_q.dt, dbl_mode, f_ext);
    assign restart  = pend_q ? prog.top : act_q.top;
    assign src_addr = addr_q;

    // active set and deferred commit
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (load_now) begin
                act_q  <= prog;
                pend_q <= 1'b0;
            end else if (blk_done && pend_q) begin
                act_q  <= prog;
                pend_q <= 1'b0;
            end
            if (ep_p && run)
                pend_q <= 1'b1;
        end
    end

    // address walker
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            ecnt_q <= '0;
            fcnt_q <= '0;
        end else if (start_p) begin
            addr_q <= load_now ? prog.top : act_q.top;
            ecnt_q <= '0;
            fcnt_q <= '0;
        end else if (acc) begin
            if (last_e) begin
                ecnt_q <= '0;
                if (last_f) begin
                    addr_q <= restart;
                    fcnt_q <= '0;
                end else begin
                    addr_q <= addr_q + step_f;
                    fcnt_q <= fcnt_q + CNT_W'(1);
                end
            end else begin
                addr_q <= addr_q + step_e;
                ecnt_q <= ecnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/sdma2d_seq.sv
module sdma2d_seq
    import sdma2d_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [RA_W-1:0]   reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wr_data,
    input  logic [RA_W-1:0]   reg_rd_addr,
    output logic [DATA_W-1:0] reg_rd_data,
    output logic              src_valid,
    output logic [ADDR_W-1:0] src_addr,
    input  logic              src_ready,
    output logic              busy,
    output logic              irq
);

    logic      run_w;
    logic      dbl_w;
    logic      rep_on_w;
    logic      start_w;
    logic      ep_w;
    logic      irq_en_w;
    logic      stat_w;
    logic      blk_done_w;
    xfer_set_t prog_w;

    sdma2d_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .wr_addr  (reg_wr_addr),
        .wr_data  (reg_wr_data),
        .rd_addr  (reg_rd_addr),
        .rd_data  (reg_rd_data),
        .blk_done (blk_done_w),
        .run      (run_w),
        .dbl_mode (dbl_w),
        .rep_on   (rep_on_w),
        .start_p  (start_w),
        .ep_p     (ep_w),
        .irq_en   (irq_en_w),
        .stat     (stat_w),
        .irq      (irq),
        .prog     (prog_w)
    );

    sdma2d_addr_gen u_gen (
        .clk       (clk),
        .rst       (rst),
        .run       (run_w),
        .start_p   (start_w),
        .ep_p      (ep_w),
        .dbl_mode  (dbl_w),
        .prog      (prog_w),
        .src_ready (src_ready),
        .src_addr  (src_addr),
        .blk_done  (blk_done_w)
    );

    assign src_valid = run_w;
    assign busy      = run_w;

endmodule

// File: rtl/sdma2d_seq_chk.sv
module sdma2d_seq_chk
    import sdma2d_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [RA_W-1:0]   reg_wr_addr,
    input logic [DATA_W-1:0] reg_wr_data,
    input logic              src_valid,
    input logic [ADDR_W-1:0] src_addr,
    input logic              src_ready,
    input logic              busy,
    input logic              irq,
    input logic              irq_en,
    input logic              stat,
    input logic              blk_done,
    input logic              rep_on
);

    logic chan_wr;
    assign chan_wr = reg_wr_en && (reg_wr_addr == RA_CHAN);

    assert_hold_on_stall_R10: assert property (@(posedge clk) disable iff (rst)
        (src_valid && !src_ready) |=> $stable(src_addr));

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_en && stat));

    assert_status_set_R9: assert property (@(posedge clk) disable iff (rst)
        blk_done |=> stat);

    assert_single_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (blk_done && !rep_on && !chan_wr) |=> !busy);

    assert_repeat_run_R8: assert property (@(posedge clk) disable iff (rst)
        (blk_done && rep_on && !chan_wr) |=> busy);

    assert_stop_write_R5: assert property (@(posedge clk) disable iff (rst)
        (chan_wr && !reg_wr_data[CB_EN]) |=> !busy);

    assert_done_on_accept_R4: assert property (@(posedge clk) disable iff (rst)
        blk_done |-> (src_valid && src_ready));

endmodule

bind sdma2d_seq sdma2d_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr),
    .reg_wr_data (reg_wr_data),
    .src_valid   (src_valid),
    .src_addr    (src_addr),
    .src_ready   (src_ready),
    .busy        (busy),
    .irq         (irq),
    .irq_en      (irq_en_w),
    .stat        (stat_w),
    .blk_done    (blk_done_w),
    .rep_on      (rep_on_w)
);

// File: tb/sdma2d_seq_tb_top.sv
module sdma2d_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_addr = '0;
    logic [31:0] reg_wr_data = '0;
    logic [2:0]  reg_rd_addr = '0;
    logic [31:0] reg_rd_data;
    logic        src_valid;
    logic [31:0] src_addr;
    logic        src_ready = 1'b0;
    logic        busy;
    logic        irq;

    always #5 clk = ~clk;

    sdma2d_seq dut_i (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .src_valid(src_valid), .src_addr(src_addr), .src_ready(src_ready),
        .busy(busy), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // bench model of programmed and active sets
    logic [31:0] p_top, a_top;
    int p_ec, p_fc, p_ei, p_fi, p_dt;
    int a_ec, a_fc, a_ei, a_fi, a_dt;
    bit m_pend, m_run, m_rep, m_dbl, m_stat, m_ien;
    int me, mf;
    logic [31:0] m_addr;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [31:0] es_of(input int dt);
        return (dt == 0) ? 32'd1 : (dt == 1) ? 32'd2 : 32'd4;
    endfunction

    function automatic logic [31:0] mstep(input int dt, input bit dbl, input int idx);
        return dbl ? es_of(dt) + 32'(idx) - 32'd1 : es_of(dt);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr_en   = 1'b1;
        reg_wr_addr = a;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd_addr = a;
        #1;
        d = reg_rd_data;
    endtask

    task automatic prog(input logic [31:0] top, input int ec, input int fc,
                        input int ei, input int fi, input int dt);
        wr(3'd2, top);
        wr(3'd3, 32'(ec));
        wr(3'd4, 32'(fc));
        wr(3'd5, 32'(ei));
        wr(3'd6, 32'(fi));
        wr(3'd7, 32'(dt));
        p_top = top; p_ec = ec; p_fc = fc; p_ei = ei; p_fi = fi; p_dt = dt;
    endtask

    task automatic copy_set();
        a_top = p_top; a_ec = p_ec; a_fc = p_fc; a_ei = p_ei; a_fi = p_fi; a_dt = p_dt;
    endtask

    task automatic chan(input bit en, input bit rep, input bit dbl, input bit ep);
        logic [31:0] d;
        d = 32'(en) << 7;
        if (rep) d = d | (32'd3 << 8);
        if (ep)  d = d | (32'd1 << 11);
        if (dbl) d = d | (32'd3 << 12);
        m_rep = rep;
        m_dbl = dbl;
        if (ep) begin
            if (!m_run) begin
                copy_set();
                m_pend = 1'b0;
            end else begin
                m_pend = 1'b1;
            end
        end
        if (en && !m_run) begin
            m_addr = a_top; me = 0; mf = 0;
        end
        m_run = en;
        wr(3'd0, d);
    endtask

    task automatic advance();
        if (me == a_ec - 1) begin
            me = 0;
            if (mf == a_fc - 1) begin
                mf = 0;
                m_stat = 1'b1;
                if (m_pend) begin
                    copy_set();
                    m_pend = 1'b0;
                end
                m_addr = a_top;
                if (!m_rep) m_run = 1'b0;
            end else begin
                m_addr = m_addr + mstep(a_dt, m_dbl, a_fi);
                mf++;
            end
        end else begin
            m_addr = m_addr + mstep(a_dt, m_dbl, a_ei);
            me++;
        end
    endtask

    // stream n accepted addresses with random stalls (R10), checking each offer
    task automatic stream(input string tag, input int n);
        int acc = 0;
        int guard = 0;
        bit v;
        while (acc < n && guard < n * 20 + 50) begin
            guard++;
            check({tag, " R5 valid"}, 32'(src_valid), 32'(m_run));
            if (src_valid)
                check({tag, " addr R10"}, src_addr, m_addr);
            v = src_valid;
            src_ready = ($urandom % 4) != 0;
            @(negedge clk);
            if (v && src_ready) begin
                acc++;
                advance();
            end
        end
        src_ready = 1'b0;
        check({tag, " accepted count"}, 32'(acc), 32'(n));
    endtask

    task automatic clear_status();
        wr(3'd1, 32'(m_ien) << 1 | 32'h8);
        m_stat = 1'b0;
    endtask

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED1));
        m_pend = 0; m_run = 0; m_rep = 0; m_dbl = 0; m_stat = 0; m_ien = 0;
        me = 0; mf = 0; m_addr = 0;
        p_top = 0; p_ec = 0; p_fc = 0; p_ei = 0; p_fi = 0; p_dt = 0;
        copy_set();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check("reset busy R5", 32'(busy), 32'd0);
        check("reset valid R5", 32'(src_valid), 32'd0);
        check("reset irq R9", 32'(irq), 32'd0);
        rd(3'd0, d); check("reset chan reg R5", d, 32'd0);
        rd(3'd1, d); check("reset irq reg R9", d, 32'd0);

        // R3 R4 R1: double-index block, 16-bit elements, negative frame stride
        prog(32'h0000_1000, 4, 3, 5, -20, 1);
        chan(0, 0, 1, 1);
        chan(1, 0, 1, 0);
        stream("dbl block R3 R4 R1", 12);
        check("single stop busy R8", 32'(busy), 32'd0);
        check("single stop valid R8", 32'(src_valid), 32'd0);
        rd(3'd1, d); check("status set R9", d & 32'h8, 32'h8);
        check("irq masked R9", 32'(irq), 32'd0);

        // R9: write 0 keeps status, enable shows irq, write 1 clears
        wr(3'd1, 32'h2); m_ien = 1;
        rd(3'd1, d); check("status kept on 0 write R9", d & 32'h8, 32'h8);
        check("irq enabled R9", 32'(irq), 32'd1);
        wr(3'd1, 32'hA); m_stat = 0;
        rd(3'd1, d); check("status cleared R9", d & 32'h8, 32'h0);
        check("irq cleared R9", 32'(irq), 32'd0);

        // R2 R1: linear, byte elements, strides ignored
        prog(32'h0000_2000, 3, 2, 100, 200, 0);
        chan(0, 0, 0, 1);
        chan(1, 0, 0, 0);
        stream("linear b8 R2 R1", 6);
        check("linear stop R8", 32'(busy), 32'd0);
        check("irq after block R9", 32'(irq), 32'd1);
        clear_status();

        // R1: codes 2 and 3 both give 4-byte steps
        prog(32'h0000_3000, 2, 2, 1, 1, 2);
        chan(1, 0, 0, 1);
        stream("b32 R1", 4);
        clear_status();
        prog(32'h0000_3100, 3, 1, 1, 1, 3);
        chan(1, 0, 0, 1);
        stream("code3 width R1", 3);
        clear_status();

        // R6: programmed writes without commit leave the active set alone
        prog(32'h0000_9000, 2, 1, 1, 1, 0);
        chan(1, 0, 0, 0);
        check("no commit keeps top R6", src_addr, 32'h0000_3100);
        stream("no commit R6", 3);
        clear_status();

        // R7 R8: commit mid-block while repeating
        prog(32'h0001_0000, 3, 3, -2, 40, 1);
        chan(0, 1, 1, 1);
        chan(1, 1, 1, 0);
        stream("repeat first part R7", 5);
        prog(32'h0002_0000, 2, 2, 9, -7, 2);
        chan(1, 1, 1, 1);
        stream("deferred commit R7 R8", 4 + 4 + 4 + 3);
        check("repeat keeps busy R8", 32'(busy), 32'd1);
        chan(0, 1, 1, 0);
        check("stop write busy R5", 32'(busy), 32'd0);
        check("stop write valid R5", 32'(src_valid), 32'd0);
        clear_status();

        // random configurations
        for (int i = 0; i < 12; i++) begin
            int ec = 1 + int'($urandom % 4);
            int fc = 1 + int'($urandom % 3);
            int ei = int'($urandom % 17) - 8;
            int fi = int'($urandom % 129) - 64;
            int dt = int'($urandom % 4);
            bit dbl = ($urandom % 3) != 0;
            prog(32'h0004_0000 + 32'(i) * 32'h100, ec, fc, ei, fi, dt);
            chan(1, 0, dbl, 1);
            stream("random R2 R3 R4", ec * fc);
            check("random stop R8", 32'(busy), 32'd0);
            clear_status();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule